// File: doc/BRIEF.md
# Quarter-Duty Segment LCD Driver

This block produces the time-multiplexed drive for a passive segment LCD with four common lines and twenty segment lines, so up to eighty segments at 1/4 duty and 1/2 bias. Every output carries a two-bit drive-level code that an external level shifter turns into a voltage. The block holds one four-bit nibble per segment line, and bit `i` of a nibble is the segment at common `i`. A nibble can be written in one of two ways. A direct write puts the supplied nibble at a digit address. A write through the holding latch places the latch's earlier contents at the address and loads the supplied nibble into the latch.

The base clock is meant to be 75 kHz. A divide-by-125 step counter gives 600 Hz common steps, and eight steps make up one 75 Hz frame. Writes go into a staging copy of the pattern, and the displayed copy is refreshed from it only at a frame boundary, so no frame shows a mix of old and new patterns. The two upper groups of four segment lines can each be handed to port use. While reset or backup is asserted, all lines are held at the low code.

Top module: `lcdq_drv`

## Requirements
- R1: Level codes are 00 low, 01 mid, 10 high and 11 released. While `rst_n` is low or `backup` is high, every common and segment code is 00 in that same cycle.
- R2: A frame has 8 steps of DIV clocks each (DIV=125 by default). In step s (0..7), common s mod 4 is driven high for s<4 and low for s>=4, and the other commons are driven mid.
- R3: In step s, an unreleased segment line k uses bit (s mod 4) of its displayed nibble. When the bit is 1, the line is driven low for s<4 and high for s>=4 (opposite of the active common). When the bit is 0, it takes the active common's level.
- R4: A cycle with `wr_dir` high stores `wr_data` as the staged nibble of digit `wr_digit`.
- R5: A cycle with `wr_lat` high (and `wr_dir` low) stores the holding latch's previous value into digit `wr_digit` and loads `wr_data` into the latch. The latch is 0 after reset.
- R6: When `wr_dir` and `wr_lat` are both high in one cycle, only the direct write takes place and the latch keeps its value.
- R7: A staged nibble is displayed from the frame that follows the next frame boundary. A write sampled on the very clock edge that ends a frame therefore appears one frame later, while a write on the edge before it appears in the new frame.
- R8: A cycle with `cfg_we` high captures `cfg_rel`. From the next cycle, bit 0 makes segment lines 12..15 output 11 and bit 1 does the same for lines 16..19. Both bits are 0 after reset.
- R9: A write whose `wr_digit` is 20 or more changes neither the pattern nor the latch.
- R10: The pattern survives backup. In the first cycle after `backup` falls, the drive restarts at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (75 kHz in the target use) |
| rst_n | input | 1 | Asynchronous active-low reset |
| backup | input | 1 | Low-power hold: all codes low, pattern kept |
| wr_dir | input | 1 | Direct nibble write strobe |
| wr_lat | input | 1 | Write-through-latch strobe |
| wr_digit | input | 5 | Segment line (digit) address |
| wr_data | input | 4 | Nibble, bit i = segment at common i |
| cfg_we | input | 1 | Group release register write |
| cfg_rel | input | 2 | Release bits for lines 12..15 and 16..19 |
| com_lvl | output | 8 | Common codes, line c at bits 2c+1:2c |
| seg_lvl | output | 40 | Segment codes, line k at bits 2k+1:2k |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a pattern write and the frame-boundary refresh of the displayed copy. The bench locks onto the frame start from the common outputs, counts exactly one frame of clocks, and places one write on the edge just before the boundary and another on the boundary edge itself. It then checks that the first write shows in the new frame and the second only in the frame after. The second pair is the two write paths, whose strobes are raised together. The bench judges the outcome by a later latch write that exposes the latch's contents on a segment line.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;

    // Drive-level codes seen by the external level shifter
    typedef enum logic [1:0] {
        LV_LOW  = 2'b00,
        LV_MID  = 2'b01,
        LV_HIGH = 2'b10,
        LV_REL  = 2'b11
    } lvl_e;

endpackage

// File: rtl/lcdq_timebase.sv
module lcdq_timebase #(
    parameter int DIV   = 125,
    parameter int STEPS = 8,
    localparam int CNT_W  = (DIV > 1) ? $clog2(DIV) : 1,
    localparam int STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    output logic [STEP_W-1:0] step,
    output logic              active,
    output logic              frame_end
);

    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(DIV - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [STEP_W-1:0] step;
        logic              active;
    } tb_t;

    tb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d = '0;
        end else if (!st_q.active) begin
            // first running cycle begins a fresh step 0
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.step   = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt  = '0;
            st_d.step = (st_q.step == STEP_LAST) ? '0 : st_q.step + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step      = st_q.step;
    assign active    = st_q.active;
    assign frame_end = st_q.active && !hold &&
                       (st_q.cnt == CNT_LAST) && (st_q.step == STEP_LAST);

endmodule

// File: rtl/lcdq_patmem.sv
module lcdq_patmem #(
    parameter int NUM_SEG = 20,
    parameter int NIB_W   = 4,
    localparam int DIG_W  = $clog2(NUM_SEG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_dir,
    input  logic                       wr_lat,
    input  logic [DIG_W-1:0]           wr_digit,
    input  logic [NIB_W-1:0]           wr_data,
    input  logic                       commit,
    output logic [NUM_SEG*NIB_W-1:0]   disp
);

    localparam logic [DIG_W:0] SEG_LIM = (DIG_W + 1)'(NUM_SEG);

    typedef struct packed {
        logic [NUM_SEG-1:0][NIB_W-1:0] stage;
        logic [NUM_SEG-1:0][NIB_W-1:0] shown;
        logic [NIB_W-1:0]              lat;
    } pm_t;

    pm_t pm_d, pm_q;
    logic hit;

    assign hit = ({1'b0, wr_digit} < SEG_LIM);

    always_comb begin
        pm_d = pm_q;
        // refresh uses the staging copy as it stood before this cycle's write
        if (commit) pm_d.shown = pm_q.stage;
        if (hit) begin
            if (wr_dir) begin
                pm_d.stage[wr_digit] = wr_data;
            end else if (wr_lat) begin
                pm_d.stage[wr_digit] = pm_q.lat;
                pm_d.lat             = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pm_q <= '0;
        else        pm_q <= pm_d;
    end

    assign disp = pm_q.shown;

endmodule

// File: rtl/lcdq_levmap.sv
module lcdq_levmap
    import lcdq_pkg::*;
#(
    parameter int NUM_COM  = 4,
    parameter int NUM_SEG  = 20,
    parameter int NUM_GRP  = 2,
    parameter int GRP_SZ   = 4,
    parameter int GRP_BASE = 12,
    localparam int COM_W   = $clog2(NUM_COM),
    localparam int STEP_W  = COM_W + 1
) (
    input  logic                       en,
    input  logic [STEP_W-1:0]          step,
    input  logic [NUM_SEG*NUM_COM-1:0] disp,
    input  logic [NUM_GRP-1:0]         rel,
    output logic [2*NUM_COM-1:0]       com_lvl,
    output logic [2*NUM_SEG-1:0]       seg_lvl
);

    logic [COM_W-1:0] cur;
    logic             neg;
    lvl_e             act_lv, opp_lv;

    assign cur    = step[COM_W-1:0];
    assign neg    = step[STEP_W-1];
    assign act_lv = neg ? LV_LOW : LV_HIGH;
    assign opp_lv = neg ? LV_HIGH : LV_LOW;

    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        assign com_lvl[2*c +: 2] = !en ? LV_LOW :
                                   ((cur == COM_W'(c)) ? act_lv : LV_MID);
    end

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        logic [NUM_COM-1:0] nib;
        logic               rel_k;
        assign nib = disp[k*NUM_COM +: NUM_COM];
        if (k >= GRP_BASE && k < GRP_BASE + NUM_GRP*GRP_SZ) begin : g_rel
            assign rel_k = rel[(k - GRP_BASE) / GRP_SZ];
        end else begin : g_fix
            assign rel_k = 1'b0;
        end
        assign seg_lvl[2*k +: 2] = !en ? LV_LOW :
                                   rel_k ? LV_REL :
                                   (nib[cur] ? opp_lv : act_lv);
    end

endmodule

// File: rtl/lcdq_drv.sv
module lcdq_drv #(
    parameter int NUM_COM = 4,
    parameter int NUM_SEG = 20,
    parameter int DIV     = 125,
    parameter int NUM_GRP = 2,
    parameter int GRP_SZ  = 4,
    localparam int DIG_W  = $clog2(NUM_SEG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 backup,
    input  logic                 wr_dir,
    input  logic                 wr_lat,
    input  logic [DIG_W-1:0]     wr_digit,
    input  logic [NUM_COM-1:0]   wr_data,
    input  logic                 cfg_we,
    input  logic [NUM_GRP-1:0]   cfg_rel,
    output logic [2*NUM_COM-1:0] com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl
);

    localparam int STEPS    = 2 * NUM_COM;
    localparam int STEP_W   = $clog2(STEPS);
    localparam int GRP_BASE = NUM_SEG - NUM_GRP * GRP_SZ;

    typedef struct packed {
        logic [NUM_GRP-1:0] rel;
    } top_t;

    top_t top_d, top_q;

    logic [STEP_W-1:0]          step;
    logic                       active;
    logic                       frame_end;
    logic [NUM_SEG*NUM_COM-1:0] disp;
    logic                       en;

    always_comb begin
        top_d = top_q;
        if (cfg_we) top_d.rel = cfg_rel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    lcdq_timebase #(
        .DIV   (DIV),
        .STEPS (STEPS)
    ) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (backup),
        .step      (step),
        .active    (active),
        .frame_end (frame_end)
    );

    lcdq_patmem #(
        .NUM_SEG (NUM_SEG),
        .NIB_W   (NUM_COM)
    ) u_pm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_dir   (wr_dir),
        .wr_lat   (wr_lat),
        .wr_digit (wr_digit),
        .wr_data  (wr_data),
        .commit   (frame_end),
        .disp     (disp)
    );

    assign en = rst_n && !backup && active;

    lcdq_levmap #(
        .NUM_COM  (NUM_COM),
        .NUM_SEG  (NUM_SEG),
        .NUM_GRP  (NUM_GRP),
        .GRP_SZ   (GRP_SZ),
        .GRP_BASE (GRP_BASE)
    ) u_map (
        .en      (en),
        .step    (step),
        .disp    (disp),
        .rel     (top_q.rel),
        .com_lvl (com_lvl),
        .seg_lvl (seg_lvl)
    );

endmodule

// File: rtl/lcdq_drv_chk.sv
module lcdq_drv_chk #(
    parameter int NUM_COM = 4,
    parameter int NUM_SEG = 20,
    parameter int NUM_GRP = 2,
    parameter int GRP_SZ  = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 backup,
    input logic                 cfg_we,
    input logic [NUM_GRP-1:0]   cfg_rel,
    input logic [2*NUM_COM-1:0] com_lvl,
    input logic [2*NUM_SEG-1:0] seg_lvl
);

    localparam int GRP_BASE = NUM_SEG - NUM_GRP * GRP_SZ;

    logic [NUM_COM-1:0] com_nm;
    logic [NUM_SEG-1:0] seg_mid;

    for (genvar c = 0; c < NUM_COM; c++) begin : g_c
        assign com_nm[c] = (com_lvl[2*c +: 2] != 2'b01);
    end
    for (genvar k = 0; k < NUM_SEG; k++) begin : g_k
        assign seg_mid[k] = (seg_lvl[2*k +: 2] == 2'b01);
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n || backup) begin
            idle_low_chk: assert (com_lvl == '0 && seg_lvl == '0);
        end
    end

    // R2
    one_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!backup && $past(!backup) && $past(rst_n)) |-> ($countones(com_nm) == 1));

    // R3
    seg_swing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_mid == '0);

    // R7
    quiet_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(com_lvl) && $stable(backup) && !$past(cfg_we)) |-> $stable(seg_lvl));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [2*GRP_SZ-1:0] grp_code;
        assign grp_code = seg_lvl[2*(GRP_BASE + g*GRP_SZ) +: 2*GRP_SZ];
        // R8
        grp_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_rel[g]) |=> (backup || grp_code == '1));
    end

endmodule

bind lcdq_drv lcdq_drv_chk #(
    .NUM_COM (NUM_COM),
    .NUM_SEG (NUM_SEG),
    .NUM_GRP (NUM_GRP),
    .GRP_SZ  (GRP_SZ)
) u_chk (.*);

// File: tb/lcdq_drv_bench.sv
module lcdq_drv_bench;

    localparam int NUM_COM  = 4;
    localparam int NUM_SEG  = 20;
    localparam int DIV      = 125;
    localparam int NUM_GRP  = 2;
    localparam int GRP_SZ   = 4;
    localparam int GRP_BASE = NUM_SEG - NUM_GRP * GRP_SZ;
    localparam int FRAME    = 2 * NUM_COM * DIV;

    // {kind[1:0] (01 direct, 10 latch, 11 both), digit[4:0], data[3:0]}
    localparam logic [10:0] VEC [6] = '{
        {2'b01, 5'd0,  4'b0001},
        {2'b01, 5'd19, 4'b1010},
        {2'b10, 5'd5,  4'b0110},
        {2'b10, 5'd7,  4'b1111},
        {2'b11, 5'd9,  4'b0011},
        {2'b10, 5'd12, 4'b0000}
    };

    logic                 clk;
    logic                 rst_n, backup, wr_dir, wr_lat, cfg_we;
    logic [4:0]           wr_digit;
    logic [3:0]           wr_data;
    logic [NUM_GRP-1:0]   cfg_rel;
    logic [2*NUM_COM-1:0] com_lvl;
    logic [2*NUM_SEG-1:0] seg_lvl;

    int total = 0;
    int bad   = 0;
    logic [3:0] mdl_mem [NUM_SEG];
    logic [3:0] mdl_lat;
    logic [NUM_GRP-1:0] mdl_rel;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    lcdq_drv u_lcdq_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .backup   (backup),
        .wr_dir   (wr_dir),
        .wr_lat   (wr_lat),
        .wr_digit (wr_digit),
        .wr_data  (wr_data),
        .cfg_we   (cfg_we),
        .cfg_rel  (cfg_rel),
        .com_lvl  (com_lvl),
        .seg_lvl  (seg_lvl)
    );

    function automatic logic [2*NUM_COM-1:0] exp_com(int s);
        logic [2*NUM_COM-1:0] r;
        for (int c = 0; c < NUM_COM; c++)
            r[2*c +: 2] = (c == s % NUM_COM) ? ((s < NUM_COM) ? 2'b10 : 2'b00) : 2'b01;
        return r;
    endfunction

    function automatic logic [2*NUM_SEG-1:0] exp_seg(int s);
        logic [2*NUM_SEG-1:0] r;
        for (int k = 0; k < NUM_SEG; k++) begin
            logic rl, on;
            rl = (k >= GRP_BASE) && mdl_rel[(k - GRP_BASE) / GRP_SZ];
            on = mdl_mem[k][s % NUM_COM];
            if (rl) r[2*k +: 2] = 2'b11;
            else    r[2*k +: 2] = (on ^ (s >= NUM_COM)) ? 2'b00 : 2'b10;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // called on the first negedge of a step 0
    task automatic sample_frame(input string req);
        for (int s = 0; s < 2*NUM_COM; s++) begin
            repeat (s == 0 ? DIV/2 : DIV) @(negedge clk);
            check("R2 common", com_lvl, exp_com(s));
            check(req, seg_lvl, exp_seg(s));
        end
    endtask

    task automatic wait_frame();
        logic [1:0] prev;
        logic found;
        prev  = com_lvl[1:0];
        found = 1'b0;
        while (!found) begin
            @(negedge clk);
            if (com_lvl[1:0] == 2'b10 && prev != 2'b10) found = 1'b1;
            prev = com_lvl[1:0];
        end
    endtask

    task automatic model_apply(input logic [1:0] kind, input logic [4:0] dig, input logic [3:0] dat);
        if (dig < NUM_SEG) begin
            if (kind[0]) mdl_mem[dig] = dat;
            else if (kind[1]) begin
                mdl_mem[dig] = mdl_lat;
                mdl_lat      = dat;
            end
        end
    endtask

    task automatic op(input logic [1:0] kind, input logic [4:0] dig, input logic [3:0] dat);
        wr_dir   = kind[0];
        wr_lat   = kind[1];
        wr_digit = dig;
        wr_data  = dat;
        @(negedge clk);
        wr_dir = 1'b0;
        wr_lat = 1'b0;
        model_apply(kind, dig, dat);
    endtask

    task automatic set_rel(input logic [NUM_GRP-1:0] v);
        cfg_we  = 1'b1;
        cfg_rel = v;
        @(negedge clk);
        cfg_we  = 1'b0;
        mdl_rel = v;
        @(negedge clk);
        check("R8 next cycle", seg_lvl, exp_seg(0) | (seg_lvl & ~exp_seg(0) & 0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; backup = 1'b0; wr_dir = 1'b0; wr_lat = 1'b0;
        cfg_we = 1'b0; cfg_rel = '0; wr_digit = '0; wr_data = '0;
        for (int k = 0; k < NUM_SEG; k++) mdl_mem[k] = '0;
        mdl_lat = '0;
        mdl_rel = '0;

        // R1: outputs low during reset
        repeat (5) @(negedge clk);
        check("R1 reset com", com_lvl, '0);
        check("R1 reset seg", seg_lvl, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 default: no group released after reset; blank pattern
        sample_frame("R3 R8 reset default");

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < 6; i++) begin
            wait_frame();
            op(VEC[i][10:9], VEC[i][8:4], VEC[i][3:0]);
            wait_frame();
            case (VEC[i][10:9])
                2'b01:   sample_frame("R3 R4 direct");
                2'b10:   sample_frame("R3 R5 latch");
                default: sample_frame("R6 both strobes");
            endcase
        end

        // R9: out-of-range digits leave pattern and latch alone
        wait_frame();
        op(2'b01, 5'd20, 4'b1111);
        op(2'b10, 5'd31, 4'b1111);
        op(2'b10, 5'd1,  4'b1001);
        wait_frame();
        sample_frame("R9 range");

        // R7: one write on the edge before the boundary, one on the boundary edge
        wait_frame();
        repeat (FRAME - 2) @(negedge clk);
        wr_dir = 1'b1; wr_digit = 5'd3; wr_data = 4'b0101;
        @(negedge clk);
        wr_digit = 5'd2; wr_data = 4'b1111;
        @(negedge clk);
        wr_dir = 1'b0;
        mdl_mem[3] = 4'b0101;
        sample_frame("R7 boundary frame");
        mdl_mem[2] = 4'b1111;
        wait_frame();
        sample_frame("R7 following frame");

        // R8: group release, each group then restore
        wait_frame();
        cfg_we = 1'b1; cfg_rel = 2'b01;
        @(negedge clk);
        cfg_we = 1'b0; mdl_rel = 2'b01;
        @(negedge clk);
        check("R8 group A next cycle", seg_lvl[2*GRP_BASE +: 2*GRP_SZ], 8'hFF);
        wait_frame();
        sample_frame("R8 group A");
        cfg_we = 1'b1; cfg_rel = 2'b10;
        @(negedge clk);
        cfg_we = 1'b0; mdl_rel = 2'b10;
        @(negedge clk);
        check("R8 group B next cycle", seg_lvl[2*(GRP_BASE+GRP_SZ) +: 2*GRP_SZ], 8'hFF);
        wait_frame();
        sample_frame("R8 group B");
        cfg_we = 1'b1; cfg_rel = 2'b00;
        @(negedge clk);
        cfg_we = 1'b0; mdl_rel = 2'b00;
        wait_frame();
        sample_frame("R8 restored");

        // R1 / R10: backup holds low, keeps pattern, restarts at step 0
        wait_frame();
        repeat (DIV + 10) @(negedge clk);
        backup = 1'b1;
        #1;
        check("R1 backup com", com_lvl, '0);
        check("R1 backup seg", seg_lvl, '0);
        repeat (300) @(negedge clk);
        check("R1 backup held", {com_lvl, seg_lvl}, '0);
        backup = 1'b0;
        @(negedge clk);
        sample_frame("R10 resume");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule